// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

A streaming eight-tap FIR filter for impulse responses that are mirror symmetric. Each time the input strobe is high, the block takes one signed 16-bit sample. The four coefficients are read from live input ports on that same strobe. Before any multiply, the filter adds each pair of taps that share a coefficient. This halves the multiplier count: four multipliers do the work of eight.

Every accepted step produces two registered results. The first is the filtered value at full 35-bit precision. The second is a copy of the input taken from the far end of the tap line. A strobe flag marks the clock cycle in which both results change.

The results are computed from the tap line as it stood before the step. After that, the line moves one place toward its old end and the new sample enters the newest position. A sample therefore first affects the output on the step after it arrives.

Top module: `sym_fir8`

## Requirements
- R1: A synchronous reset clears all eight taps, `y_out`, `x_dly` and `valid_out` to zero.
- R2: Tap 1 holds the newest sample and tap 8 the oldest. The pairs summed ahead of the multipliers are (1,8), (2,7), (3,6) and (4,5).
- R3: `coef1` scales pair (1,8), `coef2` scales (2,7), `coef3` scales (3,6) and `coef4` scales (4,5). The four products are summed as (p1+p2)+(p3+p4).
- R4: `y_out` is computed from the tap contents before the shift of the same step. The sample accepted on a step contributes to `y_out` only from the next accepted step onward.
- R5: On each accepted step, every tap takes the value of its newer neighbour, and tap 1 loads `x_in`.
- R6: On each accepted step, `x_dly` takes the value that tap 8 held before the shift.
- R7: `valid_out` is high in exactly the clock cycle that follows a cycle with `valid_in` high. In that cycle `y_out` and `x_dly` carry the new result.
- R8: A cycle with `valid_in` low changes no tap and no output, and drives `valid_out` low.
- R9: The coefficients are sampled on every accepted step, so a coefficient change affects the very next result.
- R10: Data and coefficients are signed two's complement. `y_out` is the exact 35-bit sum, with no rounding and no saturation, including for the all -32768 extreme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Advances the filter by one step |
| x_in | input | 16 | Input sample, signed |
| coef1 | input | 16 | Coefficient of the outermost pair, signed |
| coef2 | input | 16 | Coefficient of pair (2,7), signed |
| coef3 | input | 16 | Coefficient of pair (3,6), signed |
| coef4 | input | 16 | Coefficient of the innermost pair, signed |
| valid_out | output | 1 | High for one cycle when a new result is presented |
| y_out | output | 35 | Filtered sample, signed, full precision |
| x_dly | output | 16 | Input delayed to the end of the tap line |

## Verification
The assertions assume two things. First, `valid_in` and `rst` are sampled cleanly at the rising edge. Second, `rst` is held for at least one edge before any property is expected to hold. The bench changes every input only on the falling edge. It holds reset across several edges both at start-up and before a mid-run reset, and it drives `x_in` and the coefficients with any 16-bit value. The full width is legal because the datapath cannot overflow.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
    localparam int DATA_W = 16;
    localparam int COEF_W = 16;
    localparam int NTAP   = 8;
    localparam int PAIRS  = NTAP / 2;
    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(PAIRS);

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PRE_W-1:0]  pre_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/sfir_taps.sv
module sfir_taps
    import sfir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  sample_t din,
    output sample_t taps [NTAP]
);
    sample_t line_d [NTAP];
    sample_t line_q [NTAP];

    always_comb begin
        for (int k = 0; k < NTAP; k++) line_d[k] = line_q[k];
        if (adv) begin
            line_d[0] = din;
            for (int k = 1; k < NTAP; k++) line_d[k] = line_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAP; k++) line_q[k] <= '0;
        end else begin
            for (int k = 0; k < NTAP; k++) line_q[k] <= line_d[k];
        end
    end

    always_comb begin
        for (int k = 0; k < NTAP; k++) taps[k] = line_q[k];
    end

    // R5: newest tap loads the accepted sample
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        adv |=> line_q[0] == $past(din));

    generate
        for (genvar g = 1; g < NTAP; g++) begin : g_adv_chk
            // R5: each older tap takes its newer neighbour
            a_r5_advance: assert property (@(posedge clk) disable iff (rst)
                adv |=> line_q[g] == $past(line_q[g-1]));
            // R8: no movement without a strobe
            a_r8_tap_hold: assert property (@(posedge clk) disable iff (rst)
                !adv |=> $stable(line_q[g]));
        end
    endgenerate

    // R1: reset leaves the line empty
    a_r1_line_clear: assert property (@(posedge clk)
        rst |=> (line_q[0] == '0 && line_q[NTAP-1] == '0));
endmodule

// File: rtl/sfir_fold.sv
module sfir_fold
    import sfir_pkg::*;
(
    input  sample_t taps  [NTAP],
    input  coef_t   coefs [PAIRS],
    output prod_t   prods [PAIRS]
);
    generate
        for (genvar g = 0; g < PAIRS; g++) begin : g_pair
            pre_t pre_s;
            always_comb begin
                pre_s    = pre_t'(taps[g]) + pre_t'(taps[NTAP-1-g]);
                prods[g] = prod_t'(pre_s) * prod_t'(coefs[g]);
            end
        end
    endgenerate
endmodule

// File: rtl/sfir_tree.sv
module sfir_tree
    import sfir_pkg::*;
(
    input  prod_t prods [PAIRS],
    output acc_t  total
);
    localparam int HALF = PAIRS / 2;
    acc_t part [HALF];

    generate
        for (genvar g = 0; g < HALF; g++) begin : g_lvl1
            always_comb part[g] = acc_t'(prods[2*g]) + acc_t'(prods[2*g+1]);
        end
    endgenerate

    always_comb total = part[0] + part[1];
endmodule

// File: rtl/sym_fir8.sv
module sym_fir8
    import sfir_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     valid_in,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [COEF_W-1:0] coef1,
    input  logic signed [COEF_W-1:0] coef2,
    input  logic signed [COEF_W-1:0] coef3,
    input  logic signed [COEF_W-1:0] coef4,
    output logic                     valid_out,
    output logic signed [ACC_W-1:0]  y_out,
    output logic signed [DATA_W-1:0] x_dly
);
    typedef struct packed {
        logic    vld;
        acc_t    y;
        sample_t xd;
    } out_t;

    sample_t taps  [NTAP];
    coef_t   coefs [PAIRS];
    prod_t   prods [PAIRS];
    acc_t    sum_s;
    out_t    out_d;
    out_t    out_q;

    always_comb begin
        coefs[0] = coef1;
        coefs[1] = coef2;
        coefs[2] = coef3;
        coefs[3] = coef4;
    end

    sfir_taps u_taps (
        .clk  (clk),
        .rst  (rst),
        .adv  (valid_in),
        .din  (x_in),
        .taps (taps)
    );

    sfir_fold u_fold (
        .taps  (taps),
        .coefs (coefs),
        .prods (prods)
    );

    sfir_tree u_tree (
        .prods (prods),
        .total (sum_s)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = valid_in;
        if (valid_in) begin
            out_d.y  = sum_s;
            out_d.xd = taps[NTAP-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign valid_out = out_q.vld;
    assign y_out     = out_q.y;
    assign x_dly     = out_q.xd;

    // R7: result flag follows the input strobe by one clock
    a_r7_flag_rise: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    a_r7_flag_low: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    // R6: delayed copy is the oldest tap seen before the shift
    a_r6_oldest: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> x_dly == $past(taps[NTAP-1]));
    // R8: outputs hold while no step is taken
    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(y_out) && $stable(x_dly)));
    // R1: reset clears the outputs
    a_r1_out_clear: assert property (@(posedge clk)
        rst |=> (!valid_out && y_out == '0 && x_dly == '0));
endmodule

// File: tb/sim_sym_fir8.sv
module sim_sym_fir8;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               valid_in;
    logic signed [15:0] x_in, coef1, coef2, coef3, coef4;
    logic               valid_out;
    logic signed [34:0] y_out;
    logic signed [15:0] x_dly;

    int     n_run  = 0;
    int     n_fail = 0;
    longint sh [8];
    longint last_y = 0, last_x = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sym_fir8 u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .x_in(x_in),
        .coef1(coef1), .coef2(coef2), .coef3(coef3), .coef4(coef4),
        .valid_out(valid_out), .y_out(y_out), .x_dly(x_dly)
    );

    task automatic check(input string tag, input longint got, input longint exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic longint ref_y(input longint c1, input longint c2,
                                     input longint c3, input longint c4);
        longint p1, p2, p3, p4;
        p1 = c1 * (sh[0] + sh[7]);
        p2 = c2 * (sh[1] + sh[6]);
        p3 = c3 * (sh[2] + sh[5]);
        p4 = c4 * (sh[3] + sh[4]);
        return (p1 + p2) + (p3 + p4);
    endfunction

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) sh[k] = 0;
        last_y = 0; last_x = 0;
        check({tag, " valid_out"}, longint'(valid_out), 0);
        check({tag, " y_out"}, longint'(y_out), 0);
        check({tag, " x_dly"}, longint'(x_dly), 0);
    endtask

    // one clock: drive on falling edge, check just after the rising edge
    task automatic step(input string tag, input bit v, input int x,
                        input int c1, input int c2, input int c3, input int c4);
        longint ey, ex;
        @(negedge clk);
        valid_in = v; x_in = 16'(x);
        coef1 = 16'(c1); coef2 = 16'(c2); coef3 = 16'(c3); coef4 = 16'(c4);
        if (v) begin
            ey = ref_y(longint'(coef1), longint'(coef2), longint'(coef3), longint'(coef4));
            ex = sh[7];
            for (int k = 7; k > 0; k--) sh[k] = sh[k-1];
            sh[0] = longint'(x_in);
        end else begin
            ey = last_y; ex = last_x;
        end
        @(posedge clk);
        #1;
        check({tag, " R7 valid_out"}, longint'(valid_out), longint'(v));
        check({tag, " y_out"}, longint'(y_out), ey);
        check({tag, " R6 x_dly"}, longint'(x_dly), ex);
        last_y = ey; last_x = ex;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'd2024);
        rst = 1'b1; valid_in = 1'b0; x_in = '0;
        coef1 = '0; coef2 = '0; coef3 = '0; coef4 = '0;

        do_reset("R1 startup");

        // R4/R2/R3: impulse walks through pairs, distinct coefficients
        step("R4 impulse entry", 1'b1, 1, 1, 10, 100, 1000);
        for (int i = 0; i < 9; i++)
            step("R2 R3 impulse", 1'b1, 0, 1, 10, 100, 1000);

        // R5: step input, line fills one place per step
        for (int i = 0; i < 10; i++)
            step("R5 step fill", 1'b1, 7, 3, -5, 11, 2);

        // R9: coefficient change seen on the next result
        step("R9 coef change", 1'b1, 7, -100, 200, -300, 400);
        step("R9 coef change 2", 1'b1, 7, 9, 9, 9, 9);

        // R8: held-off cycles keep outputs
        for (int i = 0; i < 3; i++)
            step("R8 hold", 1'b0, 12345, 1, 2, 3, 4);
        step("R8 resume", 1'b1, -3, 1, 2, 3, 4);

        // R10: extremes at full precision
        for (int i = 0; i < 9; i++)
            step("R10 max positive", 1'b1, -32768, -32768, -32768, -32768, -32768);
        for (int i = 0; i < 9; i++)
            step("R10 min negative", 1'b1, -32768, 32767, 32767, 32767, 32767);
        for (int i = 0; i < 9; i++)
            step("R10 mixed", 1'b1, 32767, -32768, -32768, -32768, -32768);

        // random data, random coefficients, random gaps
        begin
            int c1 = 0, c2 = 0, c3 = 0, c4 = 0;
            for (int i = 0; i < 600; i++) begin
                if ($urandom % 2 == 0) begin
                    c1 = int'($signed(16'($urandom))); c2 = int'($signed(16'($urandom)));
                    c3 = int'($signed(16'($urandom))); c4 = int'($signed(16'($urandom)));
                end
                step("R4 R8 R9 random", ($urandom % 4) != 0,
                     int'($signed(16'($urandom))), c1, c2, c3, c4);
            end
        end

        // R1: mid-run reset empties the line
        do_reset("R1 midrun");
        step("R1 line empty", 1'b1, 55, 1, 1, 1, 1);
        step("R1 line empty next", 1'b1, 0, 1, 1, 1, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule